// File: doc/BRIEF.md
# Bipolar Stepper Phase Sequencer

This block turns a step pulse train into drive commands for the two full bridges of a two-phase bipolar stepper motor. It holds a position index in the range 0 to 7, one value per 45° of electrical angle. For each bridge it presents a current-direction bit and an enable bit. The step, direction, step-size and home request inputs can arrive from outside the core clock domain, so they pass together through one synchronizer. A rising edge of the synchronized step input moves the index by one position or by two. The direction input selects whether the index counts up or down.

Half stepping moves the index by one per step, so it alternates between two-bridge and one-bridge positions. Full stepping moves the index by two per step, so its parity never changes. If full stepping starts from a two-bridge position, every position keeps both windings energized. If it starts from a one-bridge position, the motor runs in single-winding wave drive. The home request returns the index to position 0 and overrides any step that arrives in the same cycle.

Top module: `stepper_phase_seq`

## Requirements
- R1: After the asynchronous reset, and on any cycle after the synchronized home request is seen low, the index is 0. Index 0 drives {phase_a, phase_b, en_a, en_b} = 4'b1111.
- R2: The outputs as {phase_a, phase_b, en_a, en_b} are fixed for each index. Index 0 gives 1111, 1 gives 1101, 2 gives 0111, 3 gives 0110, 4 gives 0011, 5 gives 0001, 6 gives 1011 and 7 gives 1010.
- R3: With half_step high and dir_cw high, each step adds 1 to the index modulo 8.
- R4: With half_step high and dir_cw low, each step subtracts 1 from the index modulo 8.
- R5: With half_step low, each step moves the index by 2 modulo 8, up when dir_cw is high and down when it is low. From an even index, both bridges stay enabled on every position.
- R6: Full stepping from an odd index visits only odd indices, and each of them enables exactly one bridge.
- R7: Wave drive can be entered in three moves: home, one half step, then full steps. In the clockwise direction this gives the indices 1, 3, 5, 7 with one bridge enabled.
- R8: A home request that arrives together with a step edge wins. Step edges that occur while home is held are lost. Releasing home while step_in is already high causes no step.
- R9: Only a low-to-high transition of step_in moves the index. Holding step_in high, holding it low, or changing dir_cw or half_step without a step edge leaves the outputs unchanged.
- R10: With SYNC_STAGES = 2, the outputs do not change in the first two clock edges after step_in rises. They take their new value at the third clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_in | input | 1 | Step pulse input; a rising edge advances the index |
| dir_cw | input | 1 | 1: index counts up; 0: index counts down |
| half_step | input | 1 | 1: move by one per step; 0: move by two |
| home_n | input | 1 | Active-low request to return to index 0 |
| phase_a | output | 1 | Current direction for bridge A |
| phase_b | output | 1 | Current direction for bridge B |
| en_a | output | 1 | Enable for bridge A |
| en_b | output | 1 | Enable for bridge B |

## Verification
The assertions check four things on every cycle. At least one bridge is always enabled. A seen home request forces the home drive pattern. The outputs hold still unless a step edge occurs. A half step always changes the number of enabled bridges, and a full step never does. The exact position order in both directions and both step sizes comes from the bench scenarios. So do the wrap between indices 7 and 0, the wave-drive entry sequence, the home priority over a coincident edge, and the exact cycle in which a step becomes visible.

// File: rtl/stepper_seq_pkg.sv
package stepper_seq_pkg;
    localparam int unsigned SEQ_W    = 3;
    localparam int unsigned SEQ_N    = 1 << SEQ_W;
    typedef logic [SEQ_W-1:0] seq_idx_t;
    localparam seq_idx_t    HOME_IDX = '0;
    localparam seq_idx_t    STRIDE_HALF = seq_idx_t'(1);
    localparam seq_idx_t    STRIDE_FULL = seq_idx_t'(2);

    // Bit order of the synchronized control bundle.
    localparam int unsigned CTL_HALF = 0;
    localparam int unsigned CTL_DIR  = 1;
    localparam int unsigned CTL_STEP = 2;
    localparam int unsigned CTL_HOME = 3;
    localparam int unsigned CTL_W    = 4;

    typedef struct packed {
        logic phase_a;
        logic phase_b;
        logic en_a;
        logic en_b;
    } bridge_drive_t;
endpackage

// File: rtl/stepper_input_sync.sv
module stepper_input_sync #(
    parameter int unsigned          STAGES    = 2,
    parameter int unsigned          WIDTH     = 4,
    parameter logic [WIDTH-1:0]     RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] chain_d [STAGES];
    logic [WIDTH-1:0] chain_q [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            assign chain_d[i] = din;
        end else begin : g_next
            assign chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain_q[i] <= RESET_VAL;
        end else begin
            for (int i = 0; i < STAGES; i++) chain_q[i] <= chain_d[i];
        end
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/stepper_seq_core.sv
module stepper_seq_core
    import stepper_seq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     step_s,
    input  logic     dir_s,
    input  logic     half_s,
    input  logic     home_s_n,
    output logic     step_evt,
    output seq_idx_t seq_idx
);
    typedef struct packed {
        seq_idx_t seq;
        logic     step_prev;
    } core_state_t;

    core_state_t st_d, st_q;
    seq_idx_t    stride;

    always_comb begin
        st_d           = st_q;
        st_d.step_prev = step_s;
        step_evt       = step_s & ~st_q.step_prev;
        stride         = half_s ? STRIDE_HALF : STRIDE_FULL;
        if (!home_s_n) begin
            st_d.seq = HOME_IDX;
        end else if (step_evt) begin
            st_d.seq = dir_s ? seq_idx_t'(st_q.seq + stride)
                             : seq_idx_t'(st_q.seq - stride);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.seq       <= HOME_IDX;
            st_q.step_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign seq_idx = st_q.seq;
endmodule

// File: rtl/stepper_phase_decode.sv
module stepper_phase_decode
    import stepper_seq_pkg::*;
(
    input  seq_idx_t      seq_idx,
    output bridge_drive_t drive
);
    seq_idx_t ahead;

    always_comb begin
        // Bridge A leads bridge B by a quarter turn (two positions).
        ahead         = seq_idx_t'(seq_idx + STRIDE_FULL);
        drive.phase_a = ~ahead[SEQ_W-1];
        drive.phase_b = ~seq_idx[SEQ_W-1];
        // Even index: both windings; odd index: only one, alternating.
        drive.en_a    = ~seq_idx[0] | seq_idx[1];
        drive.en_b    = ~seq_idx[0] | ~seq_idx[1];
    end
endmodule

// File: rtl/stepper_phase_seq.sv
module stepper_phase_seq
    import stepper_seq_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step_in,
    input  logic dir_cw,
    input  logic half_step,
    input  logic home_n,
    output logic phase_a,
    output logic phase_b,
    output logic en_a,
    output logic en_b
);
    // Step held high at reset so a high input cannot fake an edge; home asserted.
    localparam logic [CTL_W-1:0] CTL_RST = logic'(1'b1) << CTL_STEP;

    logic [CTL_W-1:0] ctl_raw, ctl_s;
    logic             step_s, dir_s, half_s, home_s_n, step_evt;
    seq_idx_t         seq_idx;
    bridge_drive_t    drive;

    always_comb begin
        ctl_raw           = '0;
        ctl_raw[CTL_HALF] = half_step;
        ctl_raw[CTL_DIR]  = dir_cw;
        ctl_raw[CTL_STEP] = step_in;
        ctl_raw[CTL_HOME] = home_n;
    end

    stepper_input_sync #(
        .STAGES    (SYNC_STAGES),
        .WIDTH     (CTL_W),
        .RESET_VAL (CTL_RST)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (ctl_raw),
        .dout (ctl_s)
    );

    assign half_s   = ctl_s[CTL_HALF];
    assign dir_s    = ctl_s[CTL_DIR];
    assign step_s   = ctl_s[CTL_STEP];
    assign home_s_n = ctl_s[CTL_HOME];

    stepper_seq_core u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_s  (step_s),
        .dir_s   (dir_s),
        .half_s  (half_s),
        .home_s_n(home_s_n),
        .step_evt(step_evt),
        .seq_idx (seq_idx)
    );

    stepper_phase_decode u_dec (
        .seq_idx(seq_idx),
        .drive  (drive)
    );

    assign phase_a = drive.phase_a;
    assign phase_b = drive.phase_b;
    assign en_a    = drive.en_a;
    assign en_b    = drive.en_b;
endmodule

// File: rtl/stepper_phase_seq_chk.sv
module stepper_phase_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic home_s_n,
    input logic step_evt,
    input logic half_s,
    input logic phase_a,
    input logic phase_b,
    input logic en_a,
    input logic en_b
);
    always @(negedge clk) begin
        if (rst_n) begin
            a_r2_some_bridge_on: assert (en_a || en_b);
        end
    end

    a_r1_home_pattern: assert property (@(posedge clk) disable iff (!rst_n)
        !home_s_n |=> (phase_a && phase_b && en_a && en_b));

    a_r8_home_beats_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (!home_s_n && step_evt) |=> (en_a && en_b && phase_a && phase_b));

    a_r9_still_without_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (home_s_n && !step_evt) |=> $stable({phase_a, phase_b, en_a, en_b}));

    // R3 / R4: a single position step swaps between one and two windings.
    a_r3_half_flips_count: assert property (@(posedge clk) disable iff (!rst_n)
        (home_s_n && step_evt && half_s) |=>
        ($countones({en_a, en_b}) != $countones($past({en_a, en_b}))));

    // R5 / R6: two-position steps keep the winding count.
    a_r5_full_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
        (home_s_n && step_evt && !half_s) |=>
        ($countones({en_a, en_b}) == $countones($past({en_a, en_b}))));
endmodule

bind stepper_phase_seq stepper_phase_seq_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .home_s_n(home_s_n),
    .step_evt(step_evt),
    .half_s  (half_s),
    .phase_a (phase_a),
    .phase_b (phase_b),
    .en_a    (en_a),
    .en_b    (en_b)
);

// File: tb/stepper_phase_seq_tb.sv
module stepper_phase_seq_tb;
    logic clk = 1'b0;
    logic rst_n, step_in, dir_cw, half_step, home_n;
    logic phase_a, phase_b, en_a, en_b;
    int   n_checks = 0;
    int   n_fail   = 0;
    int   exp_idx  = 0;
    bit   done     = 0;

    always #5 clk = ~clk;

    stepper_phase_seq u_dut (
        .clk(clk), .rst_n(rst_n), .step_in(step_in), .dir_cw(dir_cw),
        .half_step(half_step), .home_n(home_n),
        .phase_a(phase_a), .phase_b(phase_b), .en_a(en_a), .en_b(en_b)
    );

    // R2 table: {phase_a, phase_b, en_a, en_b} per index.
    function automatic logic [3:0] drive_of(int s);
        case (s)
            0: return 4'b1111;
            1: return 4'b1101;
            2: return 4'b0111;
            3: return 4'b0110;
            4: return 4'b0011;
            5: return 4'b0001;
            6: return 4'b1011;
            default: return 4'b1010;
        endcase
    endfunction

    task automatic check(string req);
        logic [3:0] got, want;
        got  = {phase_a, phase_b, en_a, en_b};
        want = drive_of(exp_idx);
        n_checks++;
        if (got !== want) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b (index %0d)", req, got, want, exp_idx);
        end
    endtask

    task automatic check_bridges(string req, int want_on);
        int got_on;
        got_on = int'(en_a) + int'(en_b);
        n_checks++;
        if (got_on != want_on) begin
            n_fail++;
            $display("FAIL %s: got %0d bridges on expected %0d", req, got_on, want_on);
        end
    endtask

    task automatic pulse(bit cw, bit half, string req);
        @(negedge clk);
        dir_cw = cw; half_step = half; step_in = 1'b1;
        repeat (2) @(negedge clk);
        check("R10 early");
        @(negedge clk);
        exp_idx = (exp_idx + (cw ? 1 : -1) * (half ? 1 : 2) + 8) % 8;
        check(req);
        step_in = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic go_home();
        @(negedge clk);
        home_n = 1'b0;
        repeat (4) @(negedge clk);
        home_n = 1'b1;
        repeat (4) @(negedge clk);
        exp_idx = 0;
        check("R1 home");
    endtask

    task automatic go_to(int s);
        go_home();
        for (int k = 0; k < s; k++) pulse(1'b1, 1'b1, "R3 reach");
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #2000000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not end, got hang expected completion");
            summary();
        end
    end

    initial begin
        rst_n = 1'b0; step_in = 1'b0; dir_cw = 1'b1; half_step = 1'b1; home_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 in reset");
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R1 after reset");

        // R3 full turn with wrap, then R4 full turn back
        for (int k = 0; k < 8; k++) pulse(1'b1, 1'b1, "R3 cw");
        for (int k = 0; k < 8; k++) pulse(1'b0, 1'b1, "R4 ccw");

        // Sweep every start index, step size and direction
        for (int s = 0; s < 8; s++) begin
            for (int m = 0; m < 4; m++) begin
                bit cw, half;
                cw   = m[0];
                half = m[1];
                go_to(s);
                if (half) pulse(cw, half, cw ? "R3 sweep" : "R4 sweep");
                else if (s % 2 == 0) begin
                    pulse(cw, half, "R5 sweep");
                    check_bridges("R5 sweep", 2);
                end else begin
                    pulse(cw, half, "R6 sweep");
                    check_bridges("R6 sweep", 1);
                end
            end
        end

        // R5 normal drive run both ways
        go_home();
        for (int k = 0; k < 5; k++) begin
            pulse(1'b1, 1'b0, "R5 cw run");
            check_bridges("R5 cw run", 2);
        end
        for (int k = 0; k < 5; k++) pulse(1'b0, 1'b0, "R5 ccw run");

        // R7 wave entry: home, one half step, then full steps
        go_home();
        pulse(1'b1, 1'b1, "R7 entry");
        for (int k = 0; k < 4; k++) begin
            pulse(1'b1, 1'b0, "R7 wave");
            check_bridges("R7 wave", 1);
        end
        for (int k = 0; k < 4; k++) pulse(1'b0, 1'b0, "R6 wave ccw");

        // R8 home together with a step edge
        go_to(3);
        @(negedge clk);
        home_n = 1'b0; step_in = 1'b1; dir_cw = 1'b1; half_step = 1'b1;
        repeat (5) @(negedge clk);
        exp_idx = 0;
        check("R8 coincident");
        home_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R8 release with step high");
        step_in = 1'b0;
        repeat (3) @(negedge clk);
        pulse(1'b1, 1'b1, "R8 after release");

        // R9 held step and mode changes without edges
        go_to(2);
        @(negedge clk);
        step_in = 1'b1; dir_cw = 1'b1; half_step = 1'b1;
        repeat (3) @(negedge clk);
        exp_idx = 3;
        check("R9 first edge");
        repeat (12) @(negedge clk);
        check("R9 held high");
        dir_cw = 1'b0; half_step = 1'b0;
        repeat (6) @(negedge clk);
        check("R9 inputs toggled, step high");
        step_in = 1'b0;
        repeat (6) @(negedge clk);
        check("R9 step low");

        done = 1;
        summary();
    end
endmodule